// File: doc/BRIEF.md
# CRC-4 Multiframe Alignment Timers

This block times the hunt for CRC-4 multiframe alignment in an E1 receiver. Frame and CRC detection sit elsewhere. The block takes four inputs from that logic: a 125 us frame pulse, a flag that says basic frame sync is lost, a flag that says CRC-4 multiframe sync is lost, and a strobe that marks the start of a received multiframe. All counting is done in frame pulses. One frame pulse is one 125 us frame.

Once basic frame sync is held and multiframe sync has not been found for 64 frames (8 ms), the block raises a reframe flag. At the same moment it starts an 8 ms toggle bit. Every 50 toggles of the 8 ms bit flip a 400 ms toggle bit. Gaining multiframe sync clears all three.

A separate 2 ms bit flips every 16 frames. While unaligned it runs from its own divider. Once aligned, the divider is reloaded on each multiframe-start strobe, so the toggles land on multiframe boundaries.

Top module: `crc4_mfa_timers`

## Requirements
- R1: While reset is asserted, and after it is released, reframe, tgl_8ms, tgl_400ms and tgl_2ms are all 0.
- R2: Count the frame pulses seen with frm_sync_lost=0 and mf_sync_lost=1, starting from the first such pulse. reframe rises on the 64th of them, and tgl_8ms rises from 0 to 1 on the same pulse.
- R3: While reframe stays set and mf_sync_lost=1, tgl_8ms inverts once every 64 frame pulses that have frm_sync_lost=0.
- R4: Every change of tgl_8ms during the search counts as one toggle, including its first rise. tgl_400ms inverts together with tgl_8ms on the 50th toggle and on every 50th toggle after that. It therefore first rises 3200 frame pulses after the search begins.
- R5: A frame pulse with mf_sync_lost=0 clears reframe, tgl_8ms, tgl_400ms and both of their counts to 0.
- R6: A frame pulse with frm_sync_lost=1 sets the 64-frame count back to zero. reframe and tgl_8ms keep their values, and a full 64 further qualifying pulses are then needed for the next event.
- R7: While mf_sync_lost=1, tgl_2ms inverts on every 16th frame pulse counted since reset, and mf_start has no effect.
- R8: While mf_sync_lost=0, a frame pulse with mf_start=1 inverts tgl_2ms and restarts its 16-frame count. Without a strobe, tgl_2ms still inverts after 16 frame pulses.
- R9: On clock cycles with frame_pulse=0 no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_pulse | input | 1 | One-cycle strobe, once per 125 us frame |
| frm_sync_lost | input | 1 | 1 while basic frame alignment is lost |
| mf_sync_lost | input | 1 | 1 while CRC-4 multiframe alignment is lost |
| mf_start | input | 1 | Multiframe-start strobe, sampled with frame_pulse |
| reframe | output | 1 | 8 ms multiframe search timeout flag |
| tgl_8ms | output | 1 | 8 ms toggle bit |
| tgl_400ms | output | 1 | 400 ms toggle bit |
| tgl_2ms | output | 1 | 2 ms alignment toggle bit |

## Verification
Every output is a register, and that register loads only on the clock edge where frame_pulse is high. Each result is therefore due one clock after the frame pulse that causes it. The bench raises the frame pulse on a falling edge and reads the outputs on the next falling edge. It then drives contrary values on the inputs during one idle cycle and reads the outputs again a cycle later, to confirm that nothing moved. Expected values come from arithmetic on the number of frames applied: the number of 8 ms toggles is k/64, and the 400 ms and 2 ms phases are derived from that count and from k/16.

// File: rtl/crc4_mfa_pkg.sv
package crc4_mfa_pkg;
  localparam int unsigned FRAMES_PER_TMO_DEF = 64;
  localparam int unsigned TOGGLES_PER_SLOW_DEF = 50;
  localparam int unsigned FRAMES_PER_MF_DEF = 16;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/crc4_rst_sync.sv
module crc4_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/crc4_search_timer.sv
module crc4_search_timer
  import crc4_mfa_pkg::*;
#(
  parameter int unsigned FRAMES_PER_TMO = FRAMES_PER_TMO_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic frm_sync_lost,
  input  logic mf_sync_lost,
  output logic reframe,
  output logic tgl_fast,
  output logic tick
);
  localparam int unsigned CW = cnt_width(FRAMES_PER_TMO);
  localparam logic [CW-1:0] LAST = CW'(FRAMES_PER_TMO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ref_q, ref_d;
  logic          tgl_q, tgl_d;

  always_comb begin
    cnt_d = cnt_q;
    ref_d = ref_q;
    tgl_d = tgl_q;
    tick  = 1'b0;
    if (frame_pulse) begin
      if (!mf_sync_lost) begin
        cnt_d = '0;
        ref_d = 1'b0;
        tgl_d = 1'b0;
      end else if (frm_sync_lost) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        cnt_d = '0;
        ref_d = 1'b1;
        tgl_d = ~tgl_q;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
      tgl_q <= 1'b0;
    end else if (frame_pulse) begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
      tgl_q <= tgl_d;
    end
  end

  assign reframe  = ref_q;
  assign tgl_fast = tgl_q;
endmodule

// File: rtl/crc4_toggle_div.sv
module crc4_toggle_div
  import crc4_mfa_pkg::*;
#(
  parameter int unsigned TOGGLES = TOGGLES_PER_SLOW_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic tgl_slow
);
  localparam int unsigned CW = cnt_width(TOGGLES);
  localparam logic [CW-1:0] LAST = CW'(TOGGLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgl_q, tgl_d;
  logic          en;

  assign en = clr | tick;

  always_comb begin
    cnt_d = cnt_q;
    tgl_d = tgl_q;
    if (clr) begin
      cnt_d = '0;
      tgl_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        tgl_d = ~tgl_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign tgl_slow = tgl_q;
endmodule

// File: rtl/crc4_align_div.sv
module crc4_align_div
  import crc4_mfa_pkg::*;
#(
  parameter int unsigned FRAMES_PER_MF = FRAMES_PER_MF_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic aligned,
  input  logic mf_start,
  output logic tgl_mf
);
  localparam int unsigned CW = cnt_width(FRAMES_PER_MF);
  localparam logic [CW-1:0] LAST = CW'(FRAMES_PER_MF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tgl_q, tgl_d;
  logic          reload;

  assign reload = (aligned & mf_start) | (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    tgl_d = tgl_q;
    if (reload) begin
      cnt_d = '0;
      tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (frame_pulse) begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign tgl_mf = tgl_q;
endmodule

// File: rtl/crc4_mfa_timers.sv
module crc4_mfa_timers
  import crc4_mfa_pkg::*;
#(
  parameter int unsigned FRAMES_PER_TMO   = FRAMES_PER_TMO_DEF,
  parameter int unsigned TOGGLES_PER_SLOW = TOGGLES_PER_SLOW_DEF,
  parameter int unsigned FRAMES_PER_MF    = FRAMES_PER_MF_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_pulse,
  input  logic frm_sync_lost,
  input  logic mf_sync_lost,
  input  logic mf_start,
  output logic reframe,
  output logic tgl_8ms,
  output logic tgl_400ms,
  output logic tgl_2ms
);
  logic core_rst_n;
  logic fast_tick;
  logic search_clr;

  crc4_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  crc4_search_timer #(.FRAMES_PER_TMO(FRAMES_PER_TMO)) u_search (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .frame_pulse   (frame_pulse),
    .frm_sync_lost (frm_sync_lost),
    .mf_sync_lost  (mf_sync_lost),
    .reframe       (reframe),
    .tgl_fast      (tgl_8ms),
    .tick          (fast_tick)
  );

  assign search_clr = frame_pulse & ~mf_sync_lost;

  crc4_toggle_div #(.TOGGLES(TOGGLES_PER_SLOW)) u_slow (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr      (search_clr),
    .tick     (fast_tick),
    .tgl_slow (tgl_400ms)
  );

  crc4_align_div #(.FRAMES_PER_MF(FRAMES_PER_MF)) u_mf (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .frame_pulse (frame_pulse),
    .aligned     (~mf_sync_lost),
    .mf_start    (mf_start),
    .tgl_mf      (tgl_2ms)
  );
endmodule

// File: rtl/crc4_mfa_timers_chk.sv
module crc4_mfa_timers_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_pulse,
  input logic frm_sync_lost,
  input logic mf_sync_lost,
  input logic mf_start,
  input logic reframe,
  input logic tgl_8ms,
  input logic tgl_400ms,
  input logic tgl_2ms
);
  // R9: nothing moves without a frame pulse
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable({reframe, tgl_8ms, tgl_400ms, tgl_2ms}));

  // R5: acquiring multiframe sync clears the search outputs
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && !mf_sync_lost) |=> (!reframe && !tgl_8ms && !tgl_400ms));

  // R2: reframe rises together with the 8 ms bit, on a frame pulse
  a_r2_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reframe) |-> (tgl_8ms && $past(frame_pulse) && !$past(frm_sync_lost)));

  // R3: the 8 ms bit only rises during a timed-out search
  a_r3_tog8_needs_reframe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgl_8ms) |-> reframe);

  // R4: the 400 ms bit is only set during a timed-out search
  a_r4_slow_needs_reframe: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_400ms |-> reframe);

  // R4: the 400 ms bit changes only in step with the 8 ms bit
  a_r4_slow_with_fast: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgl_400ms != $past(tgl_400ms)) && reframe) |-> (tgl_8ms != $past(tgl_8ms)));

  // R8: an aligned multiframe strobe flips the 2 ms bit
  a_r8_strobe_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && !mf_sync_lost && mf_start) |=> (tgl_2ms != $past(tgl_2ms)));
endmodule

bind crc4_mfa_timers crc4_mfa_timers_chk u_chk (
  .clk           (clk),
  .rst_n         (core_rst_n),
  .frame_pulse   (frame_pulse),
  .frm_sync_lost (frm_sync_lost),
  .mf_sync_lost  (mf_sync_lost),
  .mf_start      (mf_start),
  .reframe       (reframe),
  .tgl_8ms       (tgl_8ms),
  .tgl_400ms     (tgl_400ms),
  .tgl_2ms       (tgl_2ms)
);

// File: tb/sim_crc4_mfa_timers.sv
`timescale 1ns/1ps
module sim_crc4_mfa_timers;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_pulse, frm_sync_lost, mf_sync_lost, mf_start;
  logic reframe, tgl_8ms, tgl_400ms, tgl_2ms;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  crc4_mfa_timers u0 (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
    .frm_sync_lost(frm_sync_lost), .mf_sync_lost(mf_sync_lost), .mf_start(mf_start),
    .reframe(reframe), .tgl_8ms(tgl_8ms), .tgl_400ms(tgl_400ms), .tgl_2ms(tgl_2ms)
  );

  function automatic logic [3:0] outs();
    return {reframe, tgl_8ms, tgl_400ms, tgl_2ms};
  endfunction

  // mask selects which of {reframe,8ms,400ms,2ms} are compared
  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp,
                     input logic [3:0] mask);
    total++;
    if ((act & mask) !== (exp & mask)) begin
      bad++;
      $display("FAIL %s act=%b exp=%b mask=%b", tag, act, exp, mask);
    end
  endtask

  logic [3:0] snap;

  // one frame: pulse cycle, then an idle cycle with contrary inputs (R9)
  task automatic frame(input logic bl, input logic ml, input logic ms);
    @(negedge clk);
    frame_pulse = 1'b1; frm_sync_lost = bl; mf_sync_lost = ml; mf_start = ms;
    @(negedge clk);
    frame_pulse = 1'b0; frm_sync_lost = ~bl; mf_sync_lost = ~ml; mf_start = 1'b1;
    snap = outs();
    @(negedge clk);
    chk("R9 idle cycle holds outputs", outs(), snap, 4'b1111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frame_pulse = 1'b0; frm_sync_lost = 1'b0; mf_sync_lost = 1'b1; mf_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", outs(), 4'b0000, 4'b1111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after reset", outs(), 4'b0000, 4'b1111);

    // Sweep: search from reset, strobes sprinkled in while unaligned (R7)
    for (int k = 1; k <= 6500; k++) begin
      int tg;
      logic [3:0] e;
      frame(1'b0, 1'b1, (k % 7) == 0);
      tg = k / 64;
      e = {k >= 64, tg[0], (tg / 50) % 2 == 1, (k / 16) % 2 == 1};
      chk("R2 R3 R4 R7 search sweep", outs(), e, 4'b1111);
    end

    // R5: sync acquired; divider count was 4, so no 2 ms toggle yet
    frame(1'b0, 1'b0, 1'b0);
    chk("R5 clear on alignment", outs(), 4'b0000, 4'b1111);

    // R8: aligned strobe behaviour
    frame(1'b0, 1'b0, 1'b1);
    chk("R8 strobe toggles", outs(), 4'b0001, 4'b1111);
    for (int i = 0; i < 15; i++) begin
      frame(1'b0, 1'b0, 1'b0);
      chk("R8 hold between strobes", outs(), 4'b0001, 4'b1111);
    end
    frame(1'b0, 1'b0, 1'b1);
    chk("R8 strobe on 16th frame", outs(), 4'b0000, 4'b1111);
    for (int i = 0; i < 4; i++) begin
      frame(1'b0, 1'b0, 1'b0);
      chk("R8 hold before early strobe", outs(), 4'b0000, 4'b1111);
    end
    frame(1'b0, 1'b0, 1'b1);
    chk("R8 early strobe re-phases", outs(), 4'b0001, 4'b1111);
    for (int i = 0; i < 15; i++) begin
      frame(1'b0, 1'b0, 1'b0);
      chk("R8 flywheel hold", outs(), 4'b0001, 4'b1111);
    end
    frame(1'b0, 1'b0, 1'b0);
    chk("R8 flywheel toggle without strobe", outs(), 4'b0000, 4'b1111);

    // R6: basic frame loss restarts the 64-frame count
    for (int i = 0; i < 3; i++) begin
      frame(1'b1, 1'b1, 1'b0);
      chk("R6 no search while basic lost", outs(), 4'b0000, 4'b1110);
    end
    for (int i = 0; i < 63; i++) begin
      frame(1'b0, 1'b1, 1'b0);
      chk("R6 before timeout", outs(), 4'b0000, 4'b1110);
    end
    frame(1'b1, 1'b1, 1'b0);
    chk("R6 basic loss on 64th frame", outs(), 4'b0000, 4'b1110);
    for (int i = 0; i < 63; i++) begin
      frame(1'b0, 1'b1, 1'b0);
      chk("R6 restarted count", outs(), 4'b0000, 4'b1110);
    end
    frame(1'b0, 1'b1, 1'b0);
    chk("R2 R6 timeout after full restart", outs(), 4'b1100, 4'b1110);
    for (int i = 0; i < 100; i++) begin
      frame(1'b1, 1'b1, 1'b0);
      chk("R6 reframe and 8 ms hold while basic lost", outs(), 4'b1100, 4'b1110);
    end
    for (int i = 0; i < 63; i++) begin
      frame(1'b0, 1'b1, 1'b0);
      chk("R3 R6 8 ms hold", outs(), 4'b1100, 4'b1110);
    end
    frame(1'b0, 1'b1, 1'b0);
    chk("R3 R6 8 ms toggles after 64", outs(), 4'b1000, 4'b1110);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears", outs(), 4'b0000, 4'b1111);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule